// File: doc/BRIEF.md
# Indirect peripheral clock configuration register

This block is a single 32-bit control register that acts as a window onto a table of per-peripheral clock settings. Each table entry belongs to one peripheral identifier and keeps four settings: a peripheral clock enable, a generic clock enable, an 8-bit generic clock divider and a 3-bit generic clock source select. Software writes the register with an identifier, the settings and a command bit. With the command bit at 1 the settings are stored into the entry of that identifier. With the command bit at 0 the register is loaded on the following clock with the settings stored for that identifier, so a later bus read returns them.

Every entry's settings leave the block on flat output vectors, indexed by identifier, for the downstream clock gating and division logic. Identifiers 2 up to the parameter `MAX_ID` are valid table slots; the slots below 2 exist in the vectors but always stay zero.

Top module: `pclk_cfg_reg`

## Requirements
- R1: After reset the register reads 0 and every bit of every output vector is 0.
- R2: A write stores wr_data[6:0] as identifier, [10:8] as source select, [27:20] as divider, [28] as peripheral enable and [29] as generic enable; the command bit 12 and bits 7, 11, 19:13 and 31:30 always read as 0.
- R3: A write with bit 12 = 1 and an identifier from 2 to MAX_ID puts the four settings into that identifier's slot of the output vectors on the clock of the write (divider at bits [8*id +: 8], source at [3*id +: 3], enables at bit id).
- R4: A write with bit 12 = 1 and an identifier below 2 or above MAX_ID leaves every output vector unchanged.
- R5: A write with bit 12 = 0 keeps the written identifier, and on the next clock the register's four settings are replaced by the values stored for that identifier.
- R6: A read-mode write for an identifier below 2 or above MAX_ID loads zero settings on the next clock.
- R7: A write arriving in the clock right after a read-mode write takes precedence; the pending lookup is dropped.
- R8: A write-mode write changes only the addressed entry; all other entries keep their values.
- R9: Without a write, the register and the table keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write value |
| rd_data | output | 32 | Current register value |
| pclk_en_o | output | MAX_ID+1 | Peripheral clock enable per identifier |
| gclk_en_o | output | MAX_ID+1 | Generic clock enable per identifier |
| gclk_div_o | output | 8*(MAX_ID+1) | Generic clock divider per identifier |
| gclk_src_o | output | 3*(MAX_ID+1) | Generic clock source select per identifier |

## Verification
The read-back lookup of a read-mode write and a fresh bus write can fall in the same clock. The bench provokes this by issuing a read-mode write and a second write on two consecutive clocks, with both a write-mode and a read-mode follower, and judges the outcome against its reference model, which lets the new write win and discards the lookup. Random back-to-back command streams repeat the collision with varied identifiers, including out-of-range ones.

// File: rtl/pclk_cfg_reg.sv
module pclk_cfg_reg #(
  parameter int MAX_ID = 31
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [31:0]           wr_data,
  output logic [31:0]           rd_data,
  output logic [MAX_ID:0]       pclk_en_o,
  output logic [MAX_ID:0]       gclk_en_o,
  output logic [8*MAX_ID+7:0]   gclk_div_o,
  output logic [3*MAX_ID+2:0]   gclk_src_o
);
  localparam int MIN_ID = 2;
  localparam int NUM    = MAX_ID + 1;

  initial if (MAX_ID < MIN_ID || MAX_ID > 127) $error("MAX_ID out of range");

  logic [6:0] r_id;
  logic [2:0] r_src;
  logic [7:0] r_div;
  logic       r_pe, r_ge, pend;

  wire       w_cmd = wr_data[12];
  wire [6:0] w_id  = wr_data[6:0];

  logic [7:0] lk_div;
  logic [2:0] lk_src;
  logic       lk_pe, lk_ge;

  always_comb begin
    lk_div = '0;
    lk_src = '0;
    lk_pe  = 1'b0;
    lk_ge  = 1'b0;
    for (int i = 0; i < NUM; i++) begin
      if (r_id == 7'(i)) begin
        lk_div = gclk_div_o[8*i +: 8];
        lk_src = gclk_src_o[3*i +: 3];
        lk_pe  = pclk_en_o[i];
        lk_ge  = gclk_en_o[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_id  <= '0;
      r_src <= '0;
      r_div <= '0;
      r_pe  <= 1'b0;
      r_ge  <= 1'b0;
      pend  <= 1'b0;
    end else if (wr_en) begin
      r_id  <= w_id;
      r_src <= wr_data[10:8];
      r_div <= wr_data[27:20];
      r_pe  <= wr_data[28];
      r_ge  <= wr_data[29];
      pend  <= !w_cmd;
    end else if (pend) begin
      r_src <= lk_src;
      r_div <= lk_div;
      r_pe  <= lk_pe;
      r_ge  <= lk_ge;
      pend  <= 1'b0;
    end
  end

  assign rd_data = {2'b00, r_ge, r_pe, r_div, 7'b0, 1'b0, 1'b0, r_src, 1'b0, r_id};

  genvar g;
  generate
    for (g = 0; g < NUM; g++) begin : g_ent
      if (g < MIN_ID) begin : g_fixed
        assign pclk_en_o[g]        = 1'b0;
        assign gclk_en_o[g]        = 1'b0;
        assign gclk_div_o[8*g +: 8] = 8'h00;
        assign gclk_src_o[3*g +: 3] = 3'h0;
      end else begin : g_slot
        logic [7:0] div_q;
        logic [2:0] src_q;
        logic       pe_q, ge_q;
        always_ff @(posedge clk) begin
          if (!rst_n) begin
            div_q <= '0;
            src_q <= '0;
            pe_q  <= 1'b0;
            ge_q  <= 1'b0;
          end else if (wr_en && w_cmd && w_id == 7'(g)) begin
            div_q <= wr_data[27:20];
            src_q <= wr_data[10:8];
            pe_q  <= wr_data[28];
            ge_q  <= wr_data[29];
          end
        end
        assign pclk_en_o[g]         = pe_q;
        assign gclk_en_o[g]         = ge_q;
        assign gclk_div_o[8*g +: 8] = div_q;
        assign gclk_src_o[3*g +: 3] = src_q;
      end
    end
  endgenerate

  a_r3_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[12] && wr_data[6:0] >= 7'(MIN_ID) && 32'(wr_data[6:0]) <= MAX_ID)
    |=> (gclk_div_o[32'($past(wr_data[6:0]))*8 +: 8] == $past(wr_data[27:20])
         && gclk_src_o[32'($past(wr_data[6:0]))*3 +: 3] == $past(wr_data[10:8])
         && pclk_en_o[$past(wr_data[6:0])] == $past(wr_data[28])
         && gclk_en_o[$past(wr_data[6:0])] == $past(wr_data[29])));

  a_r4_bad_id_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[12] && (wr_data[6:0] < 7'(MIN_ID) || 32'(wr_data[6:0]) > MAX_ID))
    |=> ($stable(pclk_en_o) && $stable(gclk_en_o) && $stable(gclk_div_o) && $stable(gclk_src_o)));

  a_r5_lookup: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && !wr_data[12]) && !wr_en && 32'(rd_data[6:0]) <= MAX_ID)
    |=> (rd_data[27:20] == gclk_div_o[32'(rd_data[6:0])*8 +: 8]
         && rd_data[10:8] == gclk_src_o[32'(rd_data[6:0])*3 +: 3]
         && rd_data[28] == pclk_en_o[rd_data[6:0]]
         && rd_data[29] == gclk_en_o[rd_data[6:0]]));

  a_r8_one_entry: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ($countones(pclk_en_o ^ $past(pclk_en_o)) <= 1
               && $countones(gclk_en_o ^ $past(gclk_en_o)) <= 1));

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !$past(wr_en)) |=> $stable(rd_data));
endmodule

// File: tb/sim_pclk_cfg_reg.sv
module sim_pclk_cfg_reg;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_ID = 31;
  localparam int NUM = MAX_ID + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [MAX_ID:0] pclk_en_o, gclk_en_o;
  logic [8*MAX_ID+7:0] gclk_div_o;
  logic [3*MAX_ID+2:0] gclk_src_o;

  pclk_cfg_reg #(.MAX_ID(MAX_ID)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .pclk_en_o(pclk_en_o), .gclk_en_o(gclk_en_o), .gclk_div_o(gclk_div_o), .gclk_src_o(gclk_src_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  string tag = "R1";

  int m_id, m_src, m_div, m_pe, m_ge, m_pend;
  int t_src[128], t_div[128], t_pe[128], t_ge[128];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_id = 0; m_src = 0; m_div = 0; m_pe = 0; m_ge = 0; m_pend = 0;
      for (int i = 0; i < 128; i++) begin t_src[i] = 0; t_div[i] = 0; t_pe[i] = 0; t_ge[i] = 0; end
    end else if (wr_en) begin
      m_id = int'(wr_data[6:0]); m_src = int'(wr_data[10:8]); m_div = int'(wr_data[27:20]);
      m_pe = int'(wr_data[28]); m_ge = int'(wr_data[29]);
      if (wr_data[12] && m_id >= 2 && m_id <= MAX_ID) begin
        t_src[m_id] = m_src; t_div[m_id] = m_div; t_pe[m_id] = m_pe; t_ge[m_id] = m_ge;
      end
      m_pend = wr_data[12] ? 0 : 1;
    end else if (m_pend != 0) begin
      m_src = t_src[m_id]; m_div = t_div[m_id]; m_pe = t_pe[m_id]; m_ge = t_ge[m_id];
      m_pend = 0;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [31:0] exp_rd;
      int bad;
      exp_rd = 32'(m_id) | (32'(m_src) << 8) | (32'(m_div) << 20) | (32'(m_pe) << 28) | (32'(m_ge) << 29);
      checks++;
      if (rd_data !== exp_rd) begin
        errors++;
        $display("FAIL %s rd_data actual=%h expected=%h", tag, rd_data, exp_rd);
      end
      bad = -1;
      for (int i = 0; i < NUM; i++) begin
        if (pclk_en_o[i] !== t_pe[i][0] || gclk_en_o[i] !== t_ge[i][0] ||
            gclk_div_o[8*i +: 8] !== 8'(t_div[i]) || gclk_src_o[3*i +: 3] !== 3'(t_src[i]))
          if (bad < 0) bad = i;
      end
      checks++;
      if (bad >= 0) begin
        errors++;
        $display("FAIL %s entry %0d actual=pe%b ge%b div%h src%h expected=pe%0d ge%0d div%h src%h",
                 tag, bad, pclk_en_o[bad], gclk_en_o[bad], gclk_div_o[8*bad +: 8], gclk_src_o[3*bad +: 3],
                 t_pe[bad], t_ge[bad], 8'(t_div[bad]), 3'(t_src[bad]));
      end
    end
  end

  function automatic logic [31:0] mk(bit ge, bit pe, logic [7:0] div, logic [2:0] src, bit cmd, logic [6:0] id);
    return {2'b00, ge, pe, div, 7'b0, cmd, 1'b0, src, 1'b0, id};
  endfunction

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int seed;
    tag = "R1";
    idle(4);
    rst_n = 1'b1;
    idle(2);
    tag = "R2";
    wr(mk(1, 1, 8'hA5, 3'd5, 1, 7'd5) | 32'hC00F_E880);
    idle(1);
    wr(mk(0, 1, 8'h3C, 3'd2, 0, 7'd77) | 32'hC00F_E880);
    tag = "R3";
    wr(mk(1, 0, 8'h11, 3'd1, 1, 7'd2));
    wr(mk(0, 1, 8'hFF, 3'd7, 1, 7'(MAX_ID)));
    wr(mk(1, 1, 8'h42, 3'd4, 1, 7'd17));
    idle(1);
    tag = "R4";
    wr(mk(1, 1, 8'h99, 3'd3, 1, 7'd0));
    wr(mk(1, 1, 8'h99, 3'd3, 1, 7'd1));
    wr(mk(1, 1, 8'h99, 3'd3, 1, 7'(MAX_ID + 1)));
    wr(mk(1, 1, 8'h99, 3'd3, 1, 7'd127));
    idle(1);
    tag = "R5";
    wr(mk(0, 0, 8'h00, 3'd0, 0, 7'd5));
    idle(2);
    wr(mk(1, 1, 8'h77, 3'd6, 0, 7'd17));
    idle(2);
    wr(mk(1, 1, 8'h55, 3'd6, 0, 7'(MAX_ID)));
    idle(2);
    tag = "R6";
    wr(mk(1, 1, 8'hEE, 3'd7, 0, 7'd1));
    idle(2);
    wr(mk(1, 1, 8'hEE, 3'd7, 0, 7'd100));
    idle(2);
    tag = "R7";
    wr(mk(0, 0, 8'h00, 3'd0, 0, 7'd2));
    wr(mk(1, 0, 8'h6A, 3'd3, 1, 7'd9));
    idle(1);
    wr(mk(0, 0, 8'h00, 3'd0, 0, 7'd17));
    wr(mk(0, 0, 8'h00, 3'd0, 0, 7'd9));
    idle(2);
    tag = "R8";
    seed = 12345;
    for (int k = 0; k < 400; k++) begin
      seed = seed * 1103515245 + 12345;
      if (seed[3:0] == 4'd0) idle(1);
      else wr(32'(seed) ^ 32'(k << 3));
    end
    idle(2);
    tag = "R9";
    wr(mk(1, 0, 8'hC3, 3'd2, 1, 7'd20));
    idle(6);
    finish_run();
  end
endmodule